// File: doc/BRIEF.md
# ECC Memory Controller Register Bank

This block is the software-visible register file of an ECC memory controller. It sits behind a simple 32-bit bus: a write is taken on the rising clock edge when the write enable is high, and read data follows the presented address combinationally. Nine word registers hold the memory enables, the delay settings, the fault status, the video configuration, two captured fault addresses, a diagnostic word and two event counters. A build-time parameter picks one of three chip variants. The variant decides which enable bits software may write, which identity value the enable register carries, and which enable bits survive a warm reset.

A fault-capture port lets the memory datapath report an error. One strobe loads a status word and two address words. A second error that arrives while one is still pending only raises a multiple-error flag. The block drives one interrupt line: an uncorrectable error always raises it, and a correctable error raises it when software has enabled that. Any write to the status register lowers the interrupt. Variant 0 also has a small byte-wide diagnostic window of four bytes.

There are two resets, both synchronous and active high. `cold_rst` is the power-up reset and loads the variant identity into the enable register. `rst` is the warm reset and keeps a variant-dependent subset of the enable bits.

Top module: `eccreg_bank`

## Requirements
- R1: The register is selected by word index (byte address shifted right by 2): 0 enable, 1 delay, 2 fault status, 3 video, 4 fault address A, 5 fault address B, 6 diagnostic, 7 event count A, 8 event count B. Video and diagnostic store all 32 bits. An address with bits 1:0 nonzero, or an index of 9 or above, is ignored on write and reads 0.
- R2: After `cold_rst` the enable register holds the identity: 0x00000000 for variant 0, 0x10000000 for variant 1, 0x20000000 for variant 2. Delay reads 0x00000020, fault address A reads 0x07C00000, every other register reads 0, and the interrupt is low.
- R3: `rst` ANDs the enable register with 0x00000100 in variant 0, or with 0xFF000BFC in variants 1 and 2. It sets every other register to the R2 value and lowers the interrupt.
- R4: A write to the enable register stores data & 0x00000103 in variant 0, and identity | (data & 0x00000BFF) in variants 1 and 2.
- R5: A write to the delay register stores data & 0x7FFFFFFF.
- R6: A bus write to the fault status register replaces its whole contents and lowers the interrupt.
- R7: Fault address A and B cannot be written from the bus; they change only through fault capture and reset.
- R8: A capture strobe with no pending error loads the status as: bit 0 correctable, bit 2 write timeout, bit 3 uncorrectable, bits 7:4 double-word index, bits 15:8 syndrome, all other bits 0. It also loads fault address A and B from the port. A pending error means status bit 0 or bit 3 is set.
- R9: A capture strobe while an error is pending sets status bit 16 and keeps every other status bit and both fault addresses unchanged.
- R10: A capture strobe raises the interrupt on the next edge if it reports an uncorrectable error, or a correctable error while enable bits 0 and 1 are both 1. Otherwise the interrupt keeps its value.
- R11: When a status write and a capture strobe share a cycle, the written value is stored first and the capture is judged against it. An interrupt raised by the capture overrides the lowering by the write.
- R12: In variant 0, a diagnostic byte write stores at byte address modulo 4, and a read returns the byte at address modulo 4. In other variants the window reads 0 and ignores writes.
- R13: Event count A and event count B are independent storage; writing one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous, active high |
| cold_rst | input | 1 | Power-up reset, synchronous, active high |
| bus_wr_en | input | 1 | Word write strobe |
| bus_addr | input | 6 | Byte address of the word access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| flt_valid | input | 1 | Fault capture strobe |
| flt_ce | input | 1 | Reported error is correctable |
| flt_ue | input | 1 | Reported error is uncorrectable |
| flt_timeout | input | 1 | Reported write timeout |
| flt_dword | input | 4 | Double-word index within the block |
| flt_syndrome | input | 8 | Syndrome of the error |
| flt_addr_a | input | 32 | Value for fault address A |
| flt_addr_b | input | 32 | Value for fault address B |
| diag_wr_en | input | 1 | Diagnostic byte write strobe |
| diag_addr | input | 4 | Diagnostic byte address |
| diag_wdata | input | 8 | Diagnostic write byte |
| diag_rdata | output | 8 | Diagnostic read byte |
| irq | output | 1 | Interrupt request |

## Verification
A software write to the fault status register and a capture strobe from the datapath can land on the same clock edge. The bench drives both in one cycle twice. In the first case it writes 0, so no error is pending and the capture must load a fresh status and new addresses. In the second case it writes a value with the correctable bit set, so the capture may only add the multiple-error flag. Each time the bench reads back the status, the fault address and the interrupt line, and expects the interrupt raised by the capture to win over the lowering by the write.

// File: rtl/eccreg_pkg.sv
package eccreg_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_REGS = 9;

    // word indices of the main window
    localparam int IDX_ENABLE = 0;
    localparam int IDX_DELAY  = 1;
    localparam int IDX_STATUS = 2;
    localparam int IDX_VIDEO  = 3;
    localparam int IDX_FADDRA = 4;
    localparam int IDX_FADDRB = 5;
    localparam int IDX_DIAG   = 6;
    localparam int IDX_EVCNTA = 7;
    localparam int IDX_EVCNTB = 8;

    // status bit positions
    localparam int ST_CE  = 0;
    localparam int ST_TMO = 2;
    localparam int ST_UE  = 3;
    localparam int ST_DW  = 4;
    localparam int ST_SYN = 8;
    localparam int ST_ME  = 16;

    localparam logic [WORD_W-1:0] DELAY_RST  = 32'h0000_0020;
    localparam logic [WORD_W-1:0] DELAY_MASK = 32'h7FFF_FFFF;
    localparam logic [WORD_W-1:0] FADDRA_RST = 32'h07C0_0000;

    typedef struct packed {
        logic        ce;
        logic        ue;
        logic        tmo;
        logic [3:0]  dword;
        logic [7:0]  synd;
        logic [WORD_W-1:0] addr_a;
        logic [WORD_W-1:0] addr_b;
    } fault_evt_t;

    function automatic logic [WORD_W-1:0] variant_ident(input int variant);
        return WORD_W'(variant) << 28;
    endfunction

    function automatic logic [WORD_W-1:0] enable_wmask(input int variant);
        return (variant == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction

    function automatic logic [WORD_W-1:0] enable_keep(input int variant);
        return (variant == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input fault_evt_t e);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ST_CE]            = e.ce;
        w[ST_TMO]           = e.tmo;
        w[ST_UE]            = e.ue;
        w[ST_DW +: 4]       = e.dword;
        w[ST_SYN +: 8]      = e.synd;
        return w;
    endfunction

endpackage

// File: rtl/eccreg_fault.sv
module eccreg_fault
    import eccreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cold_rst,
    input  logic              st_wr,
    input  logic [WORD_W-1:0] st_wdata,
    input  logic              evt_valid,
    input  fault_evt_t        evt,
    input  logic              ce_irq_en,
    output logic [WORD_W-1:0] status_q,
    output logic [WORD_W-1:0] faddr_a_q,
    output logic [WORD_W-1:0] faddr_b_q,
    output logic              irq_q
);

    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] status_d;
    logic              pending;
    logic              raise;
    logic              load_addr;

    always_comb begin
        base      = st_wr ? st_wdata : status_q;
        pending   = base[ST_CE] | base[ST_UE];
        raise     = evt_valid && (evt.ue || (evt.ce && ce_irq_en));
        load_addr = evt_valid && !pending;
        status_d  = base;
        if (evt_valid) begin
            if (pending) status_d[ST_ME] = 1'b1;
            else         status_d = status_word(evt);
        end
    end

    always_ff @(posedge clk) begin
        if (cold_rst || rst) begin
            status_q  <= '0;
            faddr_a_q <= FADDRA_RST;
            faddr_b_q <= '0;
            irq_q     <= 1'b0;
        end else begin
            status_q <= status_d;
            if (load_addr) begin
                faddr_a_q <= evt.addr_a;
                faddr_b_q <= evt.addr_b;
            end
            if (raise)      irq_q <= 1'b1;
            else if (st_wr) irq_q <= 1'b0;
        end
    end

    // R6: a status write without a capture leaves the interrupt low
    a_r6_write_clears_irq: assert property (@(posedge clk) disable iff (rst || cold_rst)
        (st_wr && !evt_valid) |=> !irq_q);

    // R10: an uncorrectable capture always raises the interrupt
    a_r10_ue_raises: assert property (@(posedge clk) disable iff (rst || cold_rst)
        (evt_valid && evt.ue) |=> irq_q);

    // R9: a capture on a pending error sets the multiple-error flag
    a_r9_multi_flag: assert property (@(posedge clk) disable iff (rst || cold_rst)
        (evt_valid && !st_wr && (status_q[ST_CE] || status_q[ST_UE])) |=> status_q[ST_ME]);

    // R7: fault addresses move only on a capture
    a_r7_addr_stable: assert property (@(posedge clk) disable iff (rst || cold_rst)
        !evt_valid |=> ($stable(faddr_a_q) && $stable(faddr_b_q)));

endmodule

// File: rtl/eccreg_diag.sv
module eccreg_diag #(
    parameter bit PRESENT = 1'b1,
    parameter int AW      = 4,
    parameter int NBYTES  = 4
) (
    input  logic          clk,
    input  logic          cold_rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    localparam int SEL_W = $clog2(NBYTES);

    generate
        if (PRESENT) begin : g_win
            logic [7:0]       bytes_q [NBYTES];
            logic [SEL_W-1:0] sel;
            assign sel   = addr[SEL_W-1:0];
            assign rdata = bytes_q[sel];

            always_ff @(posedge clk) begin
                if (cold_rst) begin
                    for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
                end else if (wr_en) begin
                    bytes_q[sel] <= wdata;
                end
            end

            // R12: a stored byte is visible on the next cycle at the same slot
            a_r12_byte_store: assert property (@(posedge clk) disable iff (cold_rst)
                wr_en |=> (bytes_q[$past(sel)] == $past(wdata)));
        end else begin : g_none
            logic unused_diag;
            assign unused_diag = ^{clk, cold_rst, wr_en, addr, wdata};
            assign rdata = '0;
        end
    endgenerate

endmodule

// File: rtl/eccreg_bank.sv
module eccreg_bank
    import eccreg_pkg::*;
#(
    parameter int VARIANT = 0,
    parameter int AW      = 6,
    parameter int DIAG_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cold_rst,
    input  logic              bus_wr_en,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              flt_valid,
    input  logic              flt_ce,
    input  logic              flt_ue,
    input  logic              flt_timeout,
    input  logic [3:0]        flt_dword,
    input  logic [7:0]        flt_syndrome,
    input  logic [31:0]       flt_addr_a,
    input  logic [31:0]       flt_addr_b,
    input  logic              diag_wr_en,
    input  logic [DIAG_AW-1:0] diag_addr,
    input  logic [7:0]        diag_wdata,
    output logic [7:0]        diag_rdata,
    output logic              irq
);

    localparam int IW = AW - 2;
    localparam logic [WORD_W-1:0] IDENT = variant_ident(VARIANT);
    localparam logic [WORD_W-1:0] WMASK = enable_wmask(VARIANT);
    localparam logic [WORD_W-1:0] KEEP  = enable_keep(VARIANT);

    logic [IW-1:0]     widx;
    logic              aligned;
    logic [NUM_REGS-1:0] wr_hit;

    logic [WORD_W-1:0] enable_q, delay_q, video_q, diagw_q, evcnt_a_q, evcnt_b_q;
    logic [WORD_W-1:0] status_q, faddr_a_q, faddr_b_q;
    fault_evt_t        evt;

    assign widx    = bus_addr[AW-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
            assign wr_hit[i] = bus_wr_en && aligned && (widx == IW'(i));
        end
    endgenerate

    always_comb begin
        evt.ce     = flt_ce;
        evt.ue     = flt_ue;
        evt.tmo    = flt_timeout;
        evt.dword  = flt_dword;
        evt.synd   = flt_syndrome;
        evt.addr_a = flt_addr_a;
        evt.addr_b = flt_addr_b;
    end

    // enable register: power-up identity, warm-reset subset, masked write
    always_ff @(posedge clk) begin
        if (cold_rst)                enable_q <= IDENT;
        else if (rst)                enable_q <= enable_q & KEEP;
        else if (wr_hit[IDX_ENABLE]) enable_q <= IDENT | (bus_wdata & WMASK);
    end

    always_ff @(posedge clk) begin
        if (cold_rst || rst) begin
            delay_q   <= DELAY_RST;
            video_q   <= '0;
            diagw_q   <= '0;
            evcnt_a_q <= '0;
            evcnt_b_q <= '0;
        end else begin
            if (wr_hit[IDX_DELAY])  delay_q   <= bus_wdata & DELAY_MASK;
            if (wr_hit[IDX_VIDEO])  video_q   <= bus_wdata;
            if (wr_hit[IDX_DIAG])   diagw_q   <= bus_wdata;
            if (wr_hit[IDX_EVCNTA]) evcnt_a_q <= bus_wdata;
            if (wr_hit[IDX_EVCNTB]) evcnt_b_q <= bus_wdata;
        end
    end

    eccreg_fault u_fault (
        .clk       (clk),
        .rst       (rst),
        .cold_rst  (cold_rst),
        .st_wr     (wr_hit[IDX_STATUS]),
        .st_wdata  (bus_wdata),
        .evt_valid (flt_valid),
        .evt       (evt),
        .ce_irq_en (enable_q[0] & enable_q[1]),
        .status_q  (status_q),
        .faddr_a_q (faddr_a_q),
        .faddr_b_q (faddr_b_q),
        .irq_q     (irq)
    );

    eccreg_diag #(
        .PRESENT (VARIANT == 0),
        .AW      (DIAG_AW),
        .NBYTES  (4)
    ) u_diag (
        .clk      (clk),
        .cold_rst (cold_rst),
        .wr_en    (diag_wr_en),
        .addr     (diag_addr),
        .wdata    (diag_wdata),
        .rdata    (diag_rdata)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (int'(widx))
                IDX_ENABLE: bus_rdata = enable_q;
                IDX_DELAY:  bus_rdata = delay_q;
                IDX_STATUS: bus_rdata = status_q;
                IDX_VIDEO:  bus_rdata = video_q;
                IDX_FADDRA: bus_rdata = faddr_a_q;
                IDX_FADDRB: bus_rdata = faddr_b_q;
                IDX_DIAG:   bus_rdata = diagw_q;
                IDX_EVCNTA: bus_rdata = evcnt_a_q;
                IDX_EVCNTB: bus_rdata = evcnt_b_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R4: no enable bit outside identity and write mask is ever set
    a_r4_enable_bits: assert property (@(posedge clk) disable iff (cold_rst)
        (enable_q & ~(IDENT | WMASK)) == '0);

    // R5: delay register never holds bit 31
    a_r5_delay_msb: assert property (@(posedge clk) disable iff (cold_rst)
        !delay_q[31]);

    // R13: a write to event count B leaves event count A unchanged
    a_r13_evcnt_split: assert property (@(posedge clk) disable iff (rst || cold_rst)
        (wr_hit[IDX_EVCNTB] && !wr_hit[IDX_EVCNTA]) |=> $stable(evcnt_a_q));

endmodule

// File: tb/eccreg_bank_tb.sv
module eccreg_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst, cold_rst;
    logic        bus_wr_en;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] rdata_v1, rdata_v0;
    logic        flt_valid, flt_ce, flt_ue, flt_timeout;
    logic [3:0]  flt_dword;
    logic [7:0]  flt_syndrome;
    logic [31:0] flt_addr_a, flt_addr_b;
    logic        diag_wr_en;
    logic [3:0]  diag_addr;
    logic [7:0]  diag_wdata;
    logic [7:0]  drd_v1, drd_v0;
    logic        irq_v1, irq_v0;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    eccreg_bank #(.VARIANT(1)) dut_i (
        .clk(clk), .rst(rst), .cold_rst(cold_rst),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_v1),
        .flt_valid(flt_valid), .flt_ce(flt_ce), .flt_ue(flt_ue), .flt_timeout(flt_timeout),
        .flt_dword(flt_dword), .flt_syndrome(flt_syndrome),
        .flt_addr_a(flt_addr_a), .flt_addr_b(flt_addr_b),
        .diag_wr_en(diag_wr_en), .diag_addr(diag_addr), .diag_wdata(diag_wdata),
        .diag_rdata(drd_v1), .irq(irq_v1));

    eccreg_bank #(.VARIANT(0)) dut_v0_i (
        .clk(clk), .rst(rst), .cold_rst(cold_rst),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_v0),
        .flt_valid(1'b0), .flt_ce(flt_ce), .flt_ue(flt_ue), .flt_timeout(flt_timeout),
        .flt_dword(flt_dword), .flt_syndrome(flt_syndrome),
        .flt_addr_a(flt_addr_a), .flt_addr_b(flt_addr_b),
        .diag_wr_en(diag_wr_en), .diag_addr(diag_addr), .diag_wdata(diag_wdata),
        .diag_rdata(drd_v0), .irq(irq_v0));

    // {write addr, write data, read addr, expected} on the variant 1 instance
    localparam int NVEC = 12;
    localparam logic [79:0] VEC [NVEC] = '{
        {8'h00, 32'hFFFF_FFFF, 8'h00, 32'h1000_0BFF},
        {8'h04, 32'hFFFF_FFFF, 8'h04, 32'h7FFF_FFFF},
        {8'h0C, 32'hA5A5_A5A5, 8'h0C, 32'hA5A5_A5A5},
        {8'h10, 32'h1234_5678, 8'h10, 32'h07C0_0000},
        {8'h14, 32'hFFFF_FFFF, 8'h14, 32'h0000_0000},
        {8'h18, 32'h0F0F_0F0F, 8'h18, 32'h0F0F_0F0F},
        {8'h1C, 32'h1111_1111, 8'h1C, 32'h1111_1111},
        {8'h20, 32'h2222_2222, 8'h20, 32'h2222_2222},
        {8'h20, 32'h3333_3333, 8'h1C, 32'h1111_1111},
        {8'h24, 32'h0000_DEAD, 8'h24, 32'h0000_0000},
        {8'h1E, 32'h0000_0099, 8'h1C, 32'h1111_1111},
        {8'h08, 32'h0000_ABCD, 8'h08, 32'h0000_ABCD}
    };
    localparam string VTAG [NVEC] = '{"R4", "R5", "R1", "R7", "R7", "R1",
                                      "R13", "R13", "R13", "R1", "R1", "R6"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_wr_en = 0; bus_addr = '0; bus_wdata = '0;
        flt_valid = 0; flt_ce = 0; flt_ue = 0; flt_timeout = 0;
        flt_dword = '0; flt_syndrome = '0; flt_addr_a = '0; flt_addr_b = '0;
        diag_wr_en = 0; diag_addr = '0; diag_wdata = '0;
    endtask

    // one cycle: optional bus write and optional capture on the same edge
    task automatic cycle(input logic we, input logic [5:0] a, input logic [31:0] d,
                         input logic fv, input logic ce, input logic ue, input logic tmo,
                         input logic [3:0] dw, input logic [7:0] syn,
                         input logic [31:0] fa, input logic [31:0] fb);
        @(negedge clk);
        bus_wr_en = we; bus_addr = a; bus_wdata = d;
        flt_valid = fv; flt_ce = ce; flt_ue = ue; flt_timeout = tmo;
        flt_dword = dw; flt_syndrome = syn; flt_addr_a = fa; flt_addr_b = fb;
        @(posedge clk);
        #1;
        bus_wr_en = 0; flt_valid = 0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 32'h0, 32'h0);
    endtask

    task automatic cap(input logic ce, input logic ue, input logic tmo, input logic [3:0] dw,
                       input logic [7:0] syn, input logic [31:0] fa, input logic [31:0] fb);
        cycle(1'b0, 6'h00, 32'h0, 1'b1, ce, ue, tmo, dw, syn, fa, fb);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v1, output logic [31:0] v0);
        bus_addr = a;
        #2;
        v1 = rdata_v1;
        v0 = rdata_v0;
    endtask

    task automatic pulse_reset(input logic cold);
        @(negedge clk);
        if (cold) cold_rst = 1; else rst = 1;
        @(posedge clk);
        #1;
        cold_rst = 0; rst = 0;
    endtask

    task automatic dwr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        diag_wr_en = 1; diag_addr = a; diag_wdata = d;
        @(posedge clk);
        #1;
        diag_wr_en = 0;
    endtask

    initial begin : watchdog
        #500000;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] v1, v0;
        idle_inputs();
        rst = 0; cold_rst = 0;
        pulse_reset(1'b1);

        // R2: power-up values
        rd(6'h00, v1, v0); check("R2 enable v1", v1, 32'h1000_0000); check("R2 enable v0", v0, 32'h0);
        rd(6'h04, v1, v0); check("R2 delay", v1, 32'h20);
        rd(6'h10, v1, v0); check("R2 faddr A", v1, 32'h07C0_0000);
        rd(6'h08, v1, v0); check("R2 status", v1, 32'h0);
        rd(6'h20, v1, v0); check("R2 evcnt B", v1, 32'h0);
        check("R2 irq", {31'b0, irq_v1}, 32'h0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][77:72], VEC[i][71:40]);
            rd(VEC[i][37:32], v1, v0);
            check(VTAG[i], v1, VEC[i][31:0]);
        end
        rd(6'h00, v1, v0); check("R4 enable v0", v0, 32'h0000_0103);

        // R3: warm reset keeps variant subset
        pulse_reset(1'b0);
        rd(6'h00, v1, v0); check("R3 enable v1", v1, 32'h1000_0BFC); check("R3 enable v0", v0, 32'h0000_0100);
        rd(6'h04, v1, v0); check("R3 delay", v1, 32'h20);
        rd(6'h0C, v1, v0); check("R3 video", v1, 32'h0);
        rd(6'h08, v1, v0); check("R3 status", v1, 32'h0);

        // R8: fresh correctable capture, interrupt disabled by enable bits
        cap(1, 0, 0, 4'h3, 8'h5A, 32'hCAFE_0001, 32'h0BAD_0002);
        rd(6'h08, v1, v0); check("R8 status", v1, 32'h0000_5A31);
        rd(6'h10, v1, v0); check("R8 faddr A", v1, 32'hCAFE_0001);
        rd(6'h14, v1, v0); check("R8 faddr B", v1, 32'h0BAD_0002);
        check("R10 ce masked irq", {31'b0, irq_v1}, 32'h0);

        // R9 / R10: uncorrectable on a pending error
        cap(0, 1, 0, 4'h7, 8'h11, 32'h1234_0000, 32'h5678_0000);
        rd(6'h08, v1, v0); check("R9 status", v1, 32'h0001_5A31);
        rd(6'h10, v1, v0); check("R9 faddr A kept", v1, 32'hCAFE_0001);
        check("R10 ue irq", {31'b0, irq_v1}, 32'h1);

        // R6: status write clears interrupt
        wr(6'h08, 32'h0);
        rd(6'h08, v1, v0); check("R6 status", v1, 32'h0);
        check("R6 irq", {31'b0, irq_v1}, 32'h0);

        // R8: timeout-only capture, then a correctable one still loads
        cap(0, 0, 1, 4'h2, 8'h00, 32'h0000_1111, 32'h0000_2222);
        rd(6'h08, v1, v0); check("R8 timeout status", v1, 32'h0000_0024);
        cap(1, 0, 0, 4'h1, 8'h3C, 32'h0000_3333, 32'h0000_4444);
        rd(6'h08, v1, v0); check("R8 reload status", v1, 32'h0000_3C11);
        rd(6'h14, v1, v0); check("R8 reload faddr B", v1, 32'h0000_4444);

        // R10: correctable with both enable bits set
        wr(6'h08, 32'h0);
        wr(6'h00, 32'h0000_0003);
        cap(1, 0, 0, 4'h0, 8'h01, 32'h0, 32'h0);
        rd(6'h08, v1, v0); check("R10 status", v1, 32'h0000_0101);
        check("R10 ce irq", {31'b0, irq_v1}, 32'h1);

        // R11: status write and capture on the same edge
        cycle(1, 6'h08, 32'h0, 1, 0, 1, 0, 4'h4, 8'h22, 32'h0000_4444, 32'h0000_5555);
        rd(6'h08, v1, v0); check("R11 write 0 + ue", v1, 32'h0000_2248);
        rd(6'h10, v1, v0); check("R11 faddr A", v1, 32'h0000_4444);
        check("R11 irq", {31'b0, irq_v1}, 32'h1);
        cycle(1, 6'h08, 32'h1, 1, 1, 0, 0, 4'h1, 8'h01, 32'h0000_9999, 32'h0000_9999);
        rd(6'h08, v1, v0); check("R11 write ce + ce", v1, 32'h0001_0001);
        rd(6'h10, v1, v0); check("R11 faddr A kept", v1, 32'h0000_4444);
        check("R11 irq wins", {31'b0, irq_v1}, 32'h1);

        // R12: diagnostic window
        for (int b = 0; b < 4; b++) dwr(4'(b), 8'(8'h10 * (b + 1)));
        for (int b = 0; b < 4; b++) begin
            diag_addr = 4'(b); #2;
            check("R12 diag byte", {24'b0, drd_v0}, 32'(8'h10 * (b + 1)));
        end
        dwr(4'h6, 8'h77);
        diag_addr = 4'h2; #2; check("R12 diag modulo", {24'b0, drd_v0}, 32'h77);
        diag_addr = 4'hA; #2; check("R12 diag read modulo", {24'b0, drd_v0}, 32'h77);
        check("R12 no window v1", {24'b0, drd_v1}, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule